// File: doc/BRIEF.md
# Sensor Node Bus Driver

This block is the node-side controller for a two-wire, single-master sensor bus. The master owns a clock line. Every node shares one bidirectional data line with the master. The block listens to the data line at all times. When it sees a rising edge on the clock line, it aligns its bit timer to that edge and decodes a Manchester-encoded command frame. From that point, all bit timing comes from the node's local clock, which oversamples each bit period `OSR` times.

If the frame's address field matches the node's strapped address, the block presents the command nibble and a one-cycle strobe to the local sensor or actuator logic. Frames carry no checksum. A frame is dropped only if it breaks the line code or has a wrong start or end bit. When the local logic asks to reply, the block drives a fixed 10-bit Manchester frame onto the data line through an output enable. It then holds the line low for half a bit and releases it.

The tri-state pad sits outside the block. The data line comes in on `line_i`, and the block drives it through `line_o` and `line_oe_o`.

Top module: `sensor_node_driver`

## Requirements
- R1: After reset, `line_oe_o`, `cmd_valid_o` and `reply_busy_o` are 0 and `cmd_o` is 0.
- R2: A command frame is 11 bits long. In time order it holds a start bit equal to 1, the address (5 bits, MSB first), the command (4 bits, MSB first) and an end bit equal to 0. When the address equals `node_addr_i`, `cmd_valid_o` pulses high for exactly one cycle and `cmd_o` carries the command.
- R3: A well-formed frame whose address differs from `node_addr_i` raises no strobe.
- R4: Each bit lasts `OSR` local clocks and is sampled once in each half. A logic 1 is low-then-high and a logic 0 is high-then-low. If the two halves of any bit are equal, the frame is abandoned without a strobe.
- R5: A frame whose start bit is 0 or whose end bit is 1 raises no strobe.
- R6: Decoding starts only on a rising edge of `bus_clk_i`. Activity on the data line without that edge raises no strobe.
- R7: On `reply_req_i`, the block sends 10 bits: a 1, then `reply_data_i` MSB first, then a 0. Each bit lasts `OSR` clocks and uses the same Manchester polarity as R4. The first half-bit appears the cycle after the request is accepted.
- R8: `line_oe_o` is high only during a reply. After the end bit it stays high for `OSR/2` more clocks with `line_o` low, then drops.
- R9: `reply_busy_o` is high from the cycle after acceptance until the line is released. A request is dropped if it arrives while a reply is in progress or a command frame is being received.
- R10: `cmd_o` keeps the last accepted command and changes only together with a `cmd_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local node clock, `OSR` cycles per bus bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_addr_i | input | 5 | Strapped node address |
| bus_clk_i | input | 1 | Master clock line, used only for alignment at frame start |
| line_i | input | 1 | Data line as seen at the pad |
| line_o | output | 1 | Data line drive value |
| line_oe_o | output | 1 | Data line output enable |
| cmd_o | output | 4 | Last accepted command |
| cmd_valid_o | output | 1 | One-cycle strobe for an accepted command |
| reply_req_i | input | 1 | Request to send a reply frame |
| reply_data_i | input | 8 | Reply payload, latched on acceptance |
| reply_busy_o | output | 1 | Reply frame in progress |

## Verification
A receiver whose bit counter or phase has slipped shows up within one frame at the ports. The strobe is missing or comes with the wrong nibble, and this is visible two synchroniser stages plus one cycle after the end bit's second half. A transmitter fault shows on `line_o` in the very half-bit where it happens. The bench therefore compares every cycle of each reply against a frame it builds itself. Stuck rejection or address logic shows as a wrong strobe count after each directed bad frame. A stray change of `cmd_o` shows after frames that should have had no effect.

// File: rtl/sensor_bus_pkg.sv
package sensor_bus_pkg;
  localparam int ADDR_W   = 5;
  localparam int CMD_W    = 4;
  localparam int DATA_W   = 8;
  localparam int OSR_DEF  = 8;
  localparam int SYNC_DEF = 2;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[s] <= '0;
      else if (s == 0) chain[s] <= d_i;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/node_rx.sv
module node_rx #(
  parameter int OSR = 8,
  parameter int AW  = 5,
  parameter int CW  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_clk_i,
  input  logic          line_i,
  input  logic          hold_i,
  input  logic [AW-1:0] node_addr_i,
  output logic          busy_o,
  output logic [CW-1:0] cmd_o,
  output logic          cmd_valid_o
);
  localparam int FB = AW + CW + 2;
  localparam int SW = AW + CW;
  localparam int PW = $clog2(OSR);
  localparam int IW = $clog2(FB);
  localparam logic [PW-1:0] PH_A   = PW'(OSR / 4);
  localparam logic [PW-1:0] PH_B   = PW'(3 * OSR / 4);
  localparam logic [PW-1:0] PH_END = PW'(OSR - 1);
  localparam logic [IW-1:0] LAST   = IW'(FB - 1);

  logic          clk_q, rise, active, first;
  logic [PW-1:0] phase;
  logic [IW-1:0] idx;
  logic [SW-1:0] sh;

  assign rise   = bus_clk_i & ~clk_q;
  assign busy_o = active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q       <= 1'b0;
      active      <= 1'b0;
      first       <= 1'b0;
      phase       <= '0;
      idx         <= '0;
      sh          <= '0;
      cmd_o       <= '0;
      cmd_valid_o <= 1'b0;
    end else begin
      clk_q       <= bus_clk_i;
      cmd_valid_o <= 1'b0;
      if (!active) begin
        // edge cycle is phase 0 of the start bit
        if (rise && !hold_i) begin
          active <= 1'b1;
          phase  <= PW'(1);
          idx    <= '0;
        end
      end else begin
        if (phase == PH_END) begin
          phase <= '0;
          idx   <= idx + 1'b1;
        end else begin
          phase <= phase + 1'b1;
        end
        if (phase == PH_A) first <= line_i;
        if (phase == PH_B) begin
          if (line_i == first) begin
            active <= 1'b0;
          end else if (idx == '0) begin
            if (!line_i) active <= 1'b0;
          end else if (idx == LAST) begin
            active <= 1'b0;
            if (!line_i && sh[SW-1:CW] == node_addr_i) begin
              cmd_valid_o <= 1'b1;
              cmd_o       <= sh[CW-1:0];
            end
          end else begin
            sh <= {sh[SW-2:0], line_i};
          end
        end
      end
    end
  end

  assert_strobe_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  assert_strobe_from_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_valid_o) |-> $past(active));

  assert_cmd_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_o |-> $stable(cmd_o));
endmodule

// File: rtl/node_tx.sv
module node_tx #(
  parameter int OSR = 8,
  parameter int DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          line_o,
  output logic          line_oe_o
);
  localparam int FB = DW + 2;
  localparam int PW = $clog2(OSR);
  localparam int IW = $clog2(FB + 1);
  localparam logic [PW-1:0] PH_HALF = PW'(OSR / 2);
  localparam logic [PW-1:0] PH_END  = PW'(OSR - 1);
  localparam logic [PW-1:0] PH_TAIL = PW'(OSR / 2 - 1);
  localparam logic [IW-1:0] TAIL    = IW'(FB);

  logic          active, second_half, in_tail;
  logic [PW-1:0] phase;
  logic [IW-1:0] bit_no;
  logic [FB-1:0] sh;

  assign second_half = (phase >= PH_HALF);
  assign in_tail     = (bit_no == TAIL);
  assign busy_o      = active;
  assign line_oe_o   = active;

  always_comb begin
    if (!active)      line_o = 1'b1;
    else if (in_tail) line_o = 1'b0;
    else              line_o = second_half ? sh[FB-1] : ~sh[FB-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active <= 1'b0;
      phase  <= '0;
      bit_no <= '0;
      sh     <= '0;
    end else if (!active) begin
      if (start_i) begin
        active <= 1'b1;
        phase  <= '0;
        bit_no <= '0;
        sh     <= {1'b1, data_i, 1'b0};
      end
    end else if (in_tail) begin
      if (phase == PH_TAIL) active <= 1'b0;
      phase <= phase + 1'b1;
    end else if (phase == PH_END) begin
      phase  <= '0;
      bit_no <= bit_no + 1'b1;
      sh     <= {sh[FB-2:0], 1'b0};
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assert_midbit_flip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !in_tail && phase == PH_HALF) |-> (line_o != $past(line_o)));

  assert_release_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(line_oe_o) |-> ($past(line_o) == 1'b0));
endmodule

// File: rtl/sensor_node_driver.sv
module sensor_node_driver
  import sensor_bus_pkg::*;
#(
  parameter int OSR    = OSR_DEF,
  parameter int STAGES = SYNC_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] node_addr_i,
  input  logic              bus_clk_i,
  input  logic              line_i,
  output logic              line_o,
  output logic              line_oe_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              cmd_valid_o,
  input  logic              reply_req_i,
  input  logic [DATA_W-1:0] reply_data_i,
  output logic              reply_busy_o
);
  logic [1:0] pins_q;
  logic       rx_busy, tx_busy;

  bus_sync #(.W(2), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({bus_clk_i, line_i}),
    .q_o   (pins_q)
  );

  node_rx #(.OSR(OSR), .AW(ADDR_W), .CW(CMD_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_clk_i  (pins_q[1]),
    .line_i     (pins_q[0]),
    .hold_i     (tx_busy),
    .node_addr_i(node_addr_i),
    .busy_o     (rx_busy),
    .cmd_o      (cmd_o),
    .cmd_valid_o(cmd_valid_o)
  );

  node_tx #(.OSR(OSR), .DW(DATA_W)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (reply_req_i && !rx_busy),
    .data_i   (reply_data_i),
    .busy_o   (tx_busy),
    .line_o   (line_o),
    .line_oe_o(line_oe_o)
  );

  assign reply_busy_o = tx_busy;

  assert_no_overlap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_busy && tx_busy));

  assert_oe_needs_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_oe_o |-> reply_busy_o);
endmodule

// File: tb/tb_sensor_node_driver.sv
`timescale 1ns/1ps
module tb_sensor_node_driver;
  localparam logic [4:0] OWN = 5'h13;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       m_clk = 1'b0, m_drv = 1'b1;
  logic       line, line_o, line_oe, cmd_valid, req = 1'b0, busy;
  logic [3:0] cmd;
  logic [7:0] rdata = '0;

  assign line = line_oe ? line_o : m_drv;

  sensor_node_driver dut (
    .clk_i(clk), .rst_ni(rst_n), .node_addr_i(OWN), .bus_clk_i(m_clk),
    .line_i(line), .line_o(line_o), .line_oe_o(line_oe), .cmd_o(cmd),
    .cmd_valid_o(cmd_valid), .reply_req_i(req), .reply_data_i(rdata),
    .reply_busy_o(busy)
  );

  int n_tests = 0, n_fail = 0, n_strobe = 0;
  logic [3:0] last_cmd = '0;

  always @(negedge clk) if (rst_n && cmd_valid) begin
    n_strobe++;
    last_cmd = cmd;
  end

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  function automatic logic [10:0] cmd_frame(input logic [4:0] a, input logic [3:0] c);
    return {1'b1, a, c, 1'b0};
  endfunction

  // mode: 0 clean, 1 no mid-bit edge at bit k, 2 start bit 0, 3 end bit 1
  task automatic send_frame(input logic [4:0] a, input logic [3:0] c,
                            input int mode, input int k, input bit with_clk);
    logic [10:0] bits;
    bits = cmd_frame(a, c);
    if (mode == 2) bits[10] = 1'b0;
    if (mode == 3) bits[0] = 1'b1;
    for (int b = 0; b < 11; b++) begin
      for (int p = 0; p < 8; p++) begin
        @(negedge clk);
        if (b == 0 && p == 0 && with_clk) m_clk = 1'b1;
        if (b == 0 && p == 4) m_clk = 1'b0;
        if (mode == 1 && b == k) m_drv = 1'b1;
        else m_drv = (p < 4) ? ~bits[10-b] : bits[10-b];
      end
    end
    @(negedge clk);
    m_drv = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic frame_test(input logic [4:0] a, input logic [3:0] c, input int mode,
                            input int k, input bit with_clk, input string tag);
    int n0;
    logic [3:0] prev;
    bit hit;
    n0   = n_strobe;
    prev = cmd;
    hit  = (mode == 0) && with_clk && (a == OWN);
    send_frame(a, c, mode, k, with_clk);
    check((n_strobe - n0) == (hit ? 1 : 0), tag, n_strobe - n0, hit ? 1 : 0);
    if (hit) check(last_cmd == c, {tag, " cmd"}, last_cmd, c);
    else     check(cmd == prev, "R10 cmd held", cmd, prev);
  endtask

  task automatic reply_test(input logic [7:0] d, input bit inject);
    logic [9:0] fr;
    int errs, first_bad_i;
    logic exp;
    fr = {1'b1, d, 1'b0};
    errs = 0;
    first_bad_i = -1;
    @(negedge clk);
    req = 1'b1;
    rdata = d;
    @(negedge clk);
    req = 1'b0;
    check(busy === 1'b1, "R9 busy after accept", busy, 1);
    for (int i = 0; i < 84; i++) begin
      if (i > 0) @(negedge clk);
      if (inject && i == 20) begin req = 1'b1; rdata = ~d; end
      if (inject && i == 21) req = 1'b0;
      if (i / 8 < 10) exp = ((i % 8) < 4) ? ~fr[9 - i/8] : fr[9 - i/8];
      else exp = 1'b0;
      if (line_oe !== 1'b1 || line_o !== exp) begin
        errs++;
        if (first_bad_i < 0) first_bad_i = i;
      end
    end
    check(errs == 0, inject ? "R9 R7 frame during busy request" : "R7 R8 reply waveform",
          first_bad_i, -1);
    @(negedge clk);
    check(line_oe === 1'b0, "R8 released after tail", line_oe, 0);
    check(busy === 1'b0, "R9 busy cleared", busy, 0);
    repeat (4) @(negedge clk);
    check(line_oe === 1'b0, "R9 late request dropped", line_oe, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (4) @(negedge clk);
    check(line_oe === 1'b0 && cmd_valid === 1'b0 && busy === 1'b0 && cmd === 4'h0,
          "R1 reset state", {line_oe, cmd_valid, busy, cmd}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    frame_test(OWN, 4'hA, 0, 0, 1'b1, "R2 match");
    frame_test(OWN, 4'h5, 0, 0, 1'b1, "R2 match second");
    frame_test(5'h12, 4'h3, 0, 0, 1'b1, "R3 mismatch");
    frame_test(~OWN, 4'hF, 0, 0, 1'b1, "R3 mismatch inverted");
    frame_test(OWN, 4'h9, 1, 4, 1'b1, "R4 missing edge in address");
    frame_test(OWN, 4'h9, 1, 9, 1'b1, "R4 missing edge in command");
    frame_test(OWN, 4'h9, 1, 10, 1'b1, "R4 missing edge in end bit");
    frame_test(OWN, 4'h6, 2, 0, 1'b1, "R5 bad start bit");
    frame_test(OWN, 4'h6, 3, 0, 1'b1, "R5 bad end bit");
    frame_test(OWN, 4'hC, 0, 0, 1'b0, "R6 no clock edge");
    frame_test(OWN, 4'h0, 0, 0, 1'b1, "R2 recovery zero cmd");
    frame_test(OWN, 4'hF, 0, 0, 1'b1, "R2 all-ones cmd");

    for (int n = 0; n < 20; n++) begin
      logic [4:0] a;
      logic [3:0] c;
      a = ($urandom % 2 == 0) ? OWN : 5'($urandom);
      c = 4'($urandom);
      frame_test(a, c, 0, 0, 1'b1, (a == OWN) ? "R2 random match" : "R3 random");
    end

    reply_test(8'hA5, 1'b0);
    reply_test(8'h00, 1'b0);
    reply_test(8'hFF, 1'b1);
    for (int n = 0; n < 3; n++) reply_test(8'($urandom), 1'b0);

    frame_test(OWN, 4'h7, 0, 0, 1'b1, "R2 after replies");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule